// File: doc/BRIEF.md
# Clockless-link word transfer unit

This unit carries one data word at a time between a sending side and a receiving side that do not share a clock. Each side is its own clocked engine. The only things that cross between them are a forward control line, a reverse control line and the data bus. Every control line is passed through a multi-flop synchronizer before the receiving engine acts on it. The data bus is not synchronized. Instead, the control sequence guarantees that the data is stable whenever the receiver samples it.

Three signalling schemes are available through `mode_i`:

- **Source strobe.** The sender pulses the forward line to announce that a word is on the bus.
- **Destination strobe.** The receiver pulses the reverse line to ask for a word. The sender drives the word onto the bus only after it sees that request.
- **Four-phase handshake.** The forward line means "word valid" and the reverse line means "word taken". This lets each side confirm that the other acted.

The sending logic accepts a word through a request/done pair. The receiving logic presents the captured word together with a one-cycle valid pulse. In destination-strobe mode, the receiving logic also has a pull input that starts the request.

Top module: `xfer_link_top`

## Requirements
- R1: While `rst_ni` is low, and after its release with no stimulus, `busy_o`, `done_o`, `word_vld_o`, `link_fwd_o` and `link_rev_o` are 0, and `link_data_o` and `word_o` are all zeros.
- R2: `mode_i` is decoded as follows: 2'b00 selects source strobe, 2'b01 selects destination strobe, and 2'b10 and 2'b11 both select the handshake. The sending engine latches the mode when it accepts `req_i` while idle. `mode_i` must not change while either side is mid-transfer.
- R3: Source strobe, described for equal clocks with k counted in clock edges after the edge that accepts `req_i`:
  - `link_fwd_o` stays high for exactly STB_LEN source clocks.
  - The receiver captures the bus on the synchronized falling edge of the strobe, and `word_vld_o` is high at k = STB_LEN+3.
  - `done_o` pulses at k = STB_LEN+4.
- R4: Destination strobe:
  - `req_i` only arms the sender. `busy_o` is 1 while armed and `link_data_o` stays zero.
  - When `pull_i` is seen while the receiver is idle, `link_rev_o` goes high for exactly STB_LEN destination clocks.
  - The sender drives the word once it sees the request.
  - The receiver captures the word as it drops the strobe. With equal clocks, `word_vld_o` is high at k = STB_LEN after the edge that accepts `pull_i`, and `done_o` is high at k = STB_LEN+3.
- R5: If the receiver pulls in destination-strobe mode while the sender is not armed, it captures an all-zero word, and the sender raises neither `busy_o` nor `done_o`.
- R6: Handshake order:
  1. The sender drives the word and raises valid (`link_fwd_o`).
  2. The receiver captures the word and raises accepted (`link_rev_o`).
  3. The sender drops valid.
  4. The receiver drops accepted.
  5. The sender pulses `done_o`.
  
  With equal clocks, `word_vld_o` is high at k = 3 and `done_o` is high at k = 12.
- R7: `link_data_o` holds its value on every cycle in which `link_fwd_o` was already high, and it is all zeros whenever `busy_o` is 0.
- R8: A `req_i` that arrives while `busy_o` is 1 has no effect. Only the first word is delivered, and no second transfer follows.
- R9: `done_o` and `word_vld_o` are single-cycle pulses, and `done_o` rises only on the cycle the sender leaves busy.
- R10: `pull_i` has no effect unless the mode is destination strobe. In the other modes, `link_rev_o` stays 0 and no word is delivered.
- R11: Each delivered word equals the `word_i` value present when the request was accepted, even if `word_i` changes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Sending engine clock |
| dst_clk_i | input | 1 | Receiving engine clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both sides |
| mode_i | input | 2 | Signalling scheme select |
| req_i | input | 1 | Start a transfer (sender, when idle) |
| word_i | input | DATA_W | Word to send, latched on request |
| busy_o | output | 1 | Sender is mid-transfer or armed |
| done_o | output | 1 | One-cycle pulse at sender completion |
| pull_i | input | 1 | Receiver asks for a word (destination strobe) |
| word_o | output | DATA_W | Last captured word |
| word_vld_o | output | 1 | One-cycle pulse when word_o is updated |
| link_fwd_o | output | 1 | Forward control line, sender to receiver |
| link_rev_o | output | 1 | Reverse control line, receiver to sender |
| link_data_o | output | DATA_W | Data bus driven by the sender |

## Verification
The bound checker checks the following on every cycle:
- Bus stability while the forward line is held high, and an all-zero bus whenever the sender is not busy.
- The pulse shapes of `done_o` and `word_vld_o`.
- The handshake ordering, in which accepted rises only under valid and valid falls only under accepted.
- The exact strobe widths, measured by counters.

Only the bench scenarios can show the following:
- The end-to-end latencies through the synchronizers.
- That a delivered word matches the one latched at request time.
- That late requests and out-of-mode pulls are ignored.
- That a pull without an armed sender yields a zero capture.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    XM_SRC_STB = 2'b00,
    XM_DST_STB = 2'b01,
    XM_HSHAKE  = 2'b10
  } xfer_mode_e;

  // 2'b11 folds onto the handshake
  function automatic xfer_mode_e decode_mode(input logic [1:0] m);
    case (m)
      2'b00:   return XM_SRC_STB;
      2'b01:   return XM_DST_STB;
      default: return XM_HSHAKE;
    endcase
  endfunction

endpackage

// File: rtl/xfer_sync.sv
module xfer_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/xfer_src_eng.sv
module xfer_src_eng
  import xfer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STB_LEN     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fwd_o,
  input  logic              rev_i,
  output logic [DATA_W-1:0] data_o
);

  // bus hold after strobe fall: covers receiver sync plus edge detect
  localparam int TAIL_LEN = SYNC_STAGES + 2;
  localparam int CNT_MAX  = (STB_LEN > TAIL_LEN) ? STB_LEN : TAIL_LEN;
  localparam int CW       = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_STB, S_TAIL, S_ARM, S_SERVE, S_HS_ACK, S_HS_REL
  } src_state_e;

  src_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              drive_q, fwd_q, done_q;
  logic              rev_s;

  xfer_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rev_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rev_i),
    .q_o   (rev_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      drive_q <= 1'b0;
      fwd_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (req_i) begin
            data_q <= word_i;
            case (decode_mode(mode_i))
              XM_SRC_STB: begin
                fwd_q   <= 1'b1;
                drive_q <= 1'b1;
                cnt_q   <= CW'(STB_LEN - 1);
                st_q    <= S_STB;
              end
              XM_DST_STB: st_q <= S_ARM;
              default: begin
                fwd_q   <= 1'b1;
                drive_q <= 1'b1;
                st_q    <= S_HS_ACK;
              end
            endcase
          end
        end
        S_STB: begin
          if (cnt_q == '0) begin
            fwd_q <= 1'b0;
            cnt_q <= CW'(TAIL_LEN - 1);
            st_q  <= S_TAIL;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_TAIL: begin
          if (cnt_q == '0) begin
            drive_q <= 1'b0;
            done_q  <= 1'b1;
            st_q    <= S_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_ARM: begin
          if (rev_s) begin
            drive_q <= 1'b1;
            st_q    <= S_SERVE;
          end
        end
        S_SERVE: begin
          if (!rev_s) begin
            drive_q <= 1'b0;
            done_q  <= 1'b1;
            st_q    <= S_IDLE;
          end
        end
        S_HS_ACK: begin
          if (rev_s) begin
            fwd_q   <= 1'b0;
            drive_q <= 1'b0;
            st_q    <= S_HS_REL;
          end
        end
        S_HS_REL: begin
          if (!rev_s) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
  assign fwd_o  = fwd_q;
  assign data_o = drive_q ? data_q : '0;

endmodule

// File: rtl/xfer_dst_eng.sv
module xfer_dst_eng
  import xfer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STB_LEN     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              pull_i,
  input  logic              fwd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rev_o,
  output logic [DATA_W-1:0] word_o,
  output logic              vld_o
);

  localparam int CW = $clog2(STB_LEN + 1);

  typedef enum logic [1:0] {D_IDLE, D_PULL, D_ACK} dst_state_e;

  dst_state_e        st_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] word_q;
  logic              rev_q, vld_q, fwd_prev_q;
  logic              fwd_s;

  xfer_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_fwd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fwd_i),
    .q_o   (fwd_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= D_IDLE;
      cnt_q      <= '0;
      word_q     <= '0;
      rev_q      <= 1'b0;
      vld_q      <= 1'b0;
      fwd_prev_q <= 1'b0;
    end else begin
      vld_q      <= 1'b0;
      fwd_prev_q <= fwd_s;
      case (st_q)
        D_IDLE: begin
          case (decode_mode(mode_i))
            XM_SRC_STB: begin
              // falling edge of the synchronized strobe
              if (fwd_prev_q && !fwd_s) begin
                word_q <= data_i;
                vld_q  <= 1'b1;
              end
            end
            XM_DST_STB: begin
              if (pull_i) begin
                rev_q <= 1'b1;
                cnt_q <= CW'(STB_LEN - 1);
                st_q  <= D_PULL;
              end
            end
            default: begin
              if (fwd_s) begin
                word_q <= data_i;
                vld_q  <= 1'b1;
                rev_q  <= 1'b1;
                st_q   <= D_ACK;
              end
            end
          endcase
        end
        D_PULL: begin
          if (cnt_q == '0) begin
            rev_q  <= 1'b0;
            word_q <= data_i;
            vld_q  <= 1'b1;
            st_q   <= D_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        D_ACK: begin
          if (!fwd_s) begin
            rev_q <= 1'b0;
            st_q  <= D_IDLE;
          end
        end
        default: st_q <= D_IDLE;
      endcase
    end
  end

  assign rev_o  = rev_q;
  assign word_o = word_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/xfer_link_top.sv
module xfer_link_top #(
  parameter int DATA_W      = 8,
  parameter int STB_LEN     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk_i,
  input  logic              dst_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              pull_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              link_fwd_o,
  output logic              link_rev_o,
  output logic [DATA_W-1:0] link_data_o
);

  logic              fwd_w, rev_w;
  logic [DATA_W-1:0] data_w;

  xfer_src_eng #(
    .DATA_W(DATA_W), .STB_LEN(STB_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .req_i (req_i),
    .word_i(word_i),
    .busy_o(busy_o),
    .done_o(done_o),
    .fwd_o (fwd_w),
    .rev_i (rev_w),
    .data_o(data_w)
  );

  xfer_dst_eng #(
    .DATA_W(DATA_W), .STB_LEN(STB_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) u_dst (
    .clk_i (dst_clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .pull_i(pull_i),
    .fwd_i (fwd_w),
    .data_i(data_w),
    .rev_o (rev_w),
    .word_o(word_o),
    .vld_o (word_vld_o)
  );

  assign link_fwd_o  = fwd_w;
  assign link_rev_o  = rev_w;
  assign link_data_o = data_w;

endmodule

// File: rtl/xfer_link_chk.sv
module xfer_link_chk #(
  parameter int DATA_W  = 8,
  parameter int STB_LEN = 6
) (
  input logic              src_clk_i,
  input logic              dst_clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              word_vld_o,
  input logic              link_fwd_o,
  input logic              link_rev_o,
  input logic [DATA_W-1:0] link_data_o
);

  localparam int HW = $clog2(STB_LEN + 2) + 1;

  logic          hs_mode;
  logic [HW-1:0] fwd_hi_q, rev_hi_q;

  assign hs_mode = mode_i[1];

  // saturating high-time counters for strobe width checks
  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_hi_q <= '0;
    else if (!link_fwd_o) fwd_hi_q <= '0;
    else if (fwd_hi_q != '1) fwd_hi_q <= fwd_hi_q + 1'b1;
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) rev_hi_q <= '0;
    else if (!link_rev_o) rev_hi_q <= '0;
    else if (rev_hi_q != '1) rev_hi_q <= rev_hi_q + 1'b1;
  end

  a_r3_strobe_width: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && $fell(link_fwd_o)) |-> (fwd_hi_q == HW'(STB_LEN)));

  a_r4_pull_width: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && $fell(link_rev_o)) |-> (rev_hi_q == HW'(STB_LEN)));

  a_r6_ack_under_valid: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    (hs_mode && $rose(link_rev_o)) |-> link_fwd_o);

  a_r6_valid_drops_after_ack: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (hs_mode && $fell(link_fwd_o)) |-> link_rev_o);

  a_r7_bus_stable: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    (link_fwd_o && $past(link_fwd_o)) |-> $stable(link_data_o));

  a_r7_bus_zero_idle: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    !busy_o |-> (link_data_o == '0));

  a_r9_done_pulse: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_at_exit: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r9_vld_pulse: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

endmodule

bind xfer_link_top xfer_link_chk #(.DATA_W(DATA_W), .STB_LEN(STB_LEN)) u_chk (
  .src_clk_i  (src_clk_i),
  .dst_clk_i  (dst_clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .word_vld_o (word_vld_o),
  .link_fwd_o (link_fwd_o),
  .link_rev_o (link_rev_o),
  .link_data_o(link_data_o)
);

// File: tb/xfer_link_top_tb_top.sv
module xfer_link_top_tb_top;

  localparam int DW = 8;
  localparam int L  = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          req_i = 1'b0;
  logic [DW-1:0] word_i = '0;
  logic          pull_i = 1'b0;
  logic          busy_o, done_o, word_vld_o, link_fwd_o, link_rev_o;
  logic [DW-1:0] word_o, link_data_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];

  always #2 clk = ~clk;

  xfer_link_top #(.DATA_W(DW), .STB_LEN(L), .SYNC_STAGES(2)) dut_i (
    .src_clk_i  (clk),
    .dst_clk_i  (clk),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .req_i      (req_i),
    .word_i     (word_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pull_i     (pull_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .link_fwd_o (link_fwd_o),
    .link_rev_o (link_rev_o),
    .link_data_o(link_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (word_vld_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected word", int'(word_o), -1);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(word_o == e, "R11 delivered word", int'(word_o), int'(e));
        end
      end
      if (!busy_o) check(link_data_o == '0, "R7 idle bus zero", int'(link_data_o), 0);
    end
  end

  // observe from the negedge after the accepting edge; k = edges since it
  task automatic observe(input int span, input int spoil_k, input logic [DW-1:0] spoil_w,
                         output int vk, output int dk, output int nv, output int fwd_hi);
    vk = -1; dk = -1; nv = 0; fwd_hi = 0;
    for (int k = 0; k < span; k++) begin
      if (word_vld_o) begin nv++; if (vk < 0) vk = k; end
      if (done_o && dk < 0) dk = k;
      if (link_fwd_o) fwd_hi++;
      if (k == spoil_k) begin req_i = 1'b1; word_i = spoil_w; end
      else req_i = 1'b0;
      @(negedge clk);
    end
    req_i = 1'b0;
  endtask

  task automatic send(input logic [1:0] m, input logic [DW-1:0] w, input int evld,
                      input int edone, input string tag, input int spoil_k);
    int vk, dk, nv, fh;
    mode_i = m;
    @(negedge clk);
    word_i = w; req_i = 1'b1;
    exp_q.push_back(w);
    @(negedge clk);
    req_i = 1'b0; word_i = ~w;
    observe(20, spoil_k, w ^ 8'h5A, vk, dk, nv, fh);
    check(vk == evld, {tag, " valid latency"}, vk, evld);
    check(dk == edone, {tag, " done latency"}, dk, edone);
    check(nv == 1, {tag, " one word only"}, nv, 1);
    if (m == 2'b00) check(fh == L, "R3 strobe width", fh, L);
    check(!busy_o, {tag, " idle after"}, int'(busy_o), 0);
  endtask

  task automatic pull_xfer(input bit armed, input logic [DW-1:0] w, input int evld,
                           input int edone, input string tag);
    int vk, dk, nv, fh;
    mode_i = 2'b01;
    if (armed) begin
      @(negedge clk);
      word_i = w; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0; word_i = ~w;
      repeat (3) @(negedge clk);
      check(busy_o == 1'b1, "R4 armed busy", int'(busy_o), 1);
      check(link_data_o == '0, "R4 armed bus quiet", int'(link_data_o), 0);
    end
    @(negedge clk);
    pull_i = 1'b1;
    exp_q.push_back(armed ? w : '0);
    @(negedge clk);
    pull_i = 1'b0;
    observe(20, -1, '0, vk, dk, nv, fh);
    check(vk == evld, {tag, " valid latency"}, vk, evld);
    check(dk == edone, {tag, " done latency"}, dk, edone);
    check(nv == 1, {tag, " one word only"}, nv, 1);
    check(!busy_o, {tag, " idle after"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy_o && !done_o && !word_vld_o && !link_fwd_o && !link_rev_o,
          "R1 reset controls", int'({busy_o, done_o, word_vld_o, link_fwd_o, link_rev_o}), 0);
    check(word_o == '0 && link_data_o == '0, "R1 reset data", int'(word_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy_o && !link_fwd_o && !link_rev_o && word_o == '0, "R1 after release",
          int'({busy_o, link_fwd_o, link_rev_o}), 0);

    // R3 source strobe, R11 latch
    send(2'b00, 8'hA5, L + 3, L + 4, "R3", -1);
    send(2'b00, 8'h3C, L + 3, L + 4, "R3", -1);
    // R6 handshake
    send(2'b10, 8'h81, 3, 12, "R6", -1);
    // R2 mode 11 behaves as handshake
    send(2'b11, 8'h7E, 3, 12, "R2", -1);
    // R8 late request during handshake and during strobe
    send(2'b10, 8'hC3, 3, 12, "R8", 2);
    send(2'b00, 8'h19, L + 3, L + 4, "R8", 4);
    // R4 destination strobe
    pull_xfer(1'b1, 8'hE7, L, L + 3, "R4");
    // R5 pull with sender not armed
    pull_xfer(1'b0, 8'h00, L, -1, "R5");

    // R10 pull outside destination-strobe mode
    for (int mm = 0; mm < 3; mm++) begin
      int revs = 0, vlds = 0;
      mode_i = (mm == 0) ? 2'b00 : ((mm == 1) ? 2'b10 : 2'b11);
      @(negedge clk);
      pull_i = 1'b1;
      @(negedge clk);
      pull_i = 1'b0;
      for (int k = 0; k < 15; k++) begin
        if (link_rev_o) revs++;
        if (word_vld_o) vlds++;
        @(negedge clk);
      end
      check(revs == 0, "R10 reverse line quiet", revs, 0);
      check(vlds == 0, "R10 no word", vlds, 0);
    end

    check(exp_q.size() == 0, "R11 all words delivered", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule